// File: doc/BRIEF.md
# Streaming Five-Point Averaging Stencil with Partial-Sum Reuse

This block takes a grid of `ROWS` by `COLS` unsigned samples, streamed in raster order at up to one sample per cycle, and produces the five-point average for every interior grid position. The average of a position is built from the sample itself and its north, west, east and south neighbours, scaled by one fifth. The result stream carries the row and column of each result and a marker on the last result of each row.

A direct form needs four additions for each result. This block uses three. When a sample arrives, the block adds it to the sample diagonally above and to its right in the previous row. That pair sum is the east-plus-south half of one result, and the same value returns one row later as the north-plus-west half of another result. Each pair sum is computed once and held in a row-sized store with one extra holding register. Each result then needs two more additions: the held pair sum and the centre sample. A second row store keeps the previous input row, so every input sample is taken from the stream only once. The one-fifth scale is a multiply by a fixed-point constant with round-to-nearest, so no floating point is used. A frame-start flag on the input restarts the position count at the top-left corner.

Top module: `stencil_reuse_avg`

## Requirements
- R1: Each result equals `((N + W + C + E + S) * K + 2^(FRAC_W-1)) >> FRAC_W`, where N, W, C, E and S are the five neighbourhood samples, `K = floor((2^FRAC_W + 2) / 5)` (13107 for FRAC_W = 16), and the result is DATA_W bits wide.
- R2: Results are produced only for rows 1 to ROWS-2 and columns 1 to COLS-2, in raster order, exactly one per interior position of each complete frame, and never for a border position.
- R3: `out_row` and `out_col` give the grid row and column of the result they come with.
- R4: `out_eol` is high on a result exactly when its column is COLS-2.
- R5: The result for row r-1, column c appears on the output 1+OUT_PIPE cycles after the clock edge that accepts the sample at row r, column c (2 cycles by default).
- R6: An accepted sample with `in_sof` high is taken as row 0, column 0, whatever position the block expected. The earlier frame is dropped, and its results already produced remain valid.
- R7: Cycles with `in_valid` low change no state and produce no result, so idle gaps anywhere in a frame leave every result unchanged.
- R8: `in_ready` is low while reset is asserted and high from the first clock edge after reset is released.
- R9: After the last sample of a frame, the next accepted sample without `in_sof` is taken as row 0, column 0 of a new frame.
- R10: While reset is asserted, `out_valid` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Input sample is present |
| in_ready | output | 1 | Block accepts a sample this cycle |
| in_sof | input | 1 | Sample is row 0, column 0 of a new frame |
| in_data | input | DATA_W | Input sample, unsigned |
| out_valid | output | 1 | Result is present this cycle |
| out_data | output | DATA_W | Scaled five-point average |
| out_row | output | RW | Row of the result |
| out_col | output | CW | Column of the result |
| out_eol | output | 1 | Last result of its row |

## Verification
The bench builds the block with a 5-row by 6-column grid, 16-bit data, a 16-bit fraction and the registered output stage. With a grid this small, every frame runs through the border columns, the row wrap and the frame wrap within a few dozen samples. That makes it practical to test an abandoned partial frame, frames that follow each other with no frame-start flag, random idle gaps, and all-maximum and all-zero frames, where the rounding reaches its highest and lowest values. A scoreboard records the required cycle for every expected result, so a wrong latency is caught as well as a wrong value or tag.

// File: rtl/stencil_pkg.sv
package stencil_pkg;

   // Fixed-point code of one fifth with FRAC_W fraction bits, rounded to nearest.
   function automatic int unsigned fifth_coef(input int unsigned frac_w);
      return ((32'd1 << frac_w) + 32'd2) / 32'd5;
   endfunction

   // Width that holds the sum of five DATA_W-bit samples.
   function automatic int unsigned sum5_width(input int unsigned data_w);
      return data_w + 3;
   endfunction

endpackage

// File: rtl/stencil_raster_pos.sv
module stencil_raster_pos #(
   parameter int ROWS = 48,
   parameter int COLS = 64,
   parameter int RW   = $clog2(ROWS),
   parameter int CW   = $clog2(COLS)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          step,
   input  logic          restart,
   output logic [RW-1:0] cur_row,
   output logic [CW-1:0] cur_col
);

   logic [RW-1:0] row_q;
   logic [CW-1:0] col_q;
   logic          last_col;
   logic          last_row;

   if (ROWS < 2 || COLS < 2) begin : g_bad_dims
      $error("stencil_raster_pos: grid needs at least 2 rows and 2 columns");
   end

   assign cur_row  = restart ? '0 : row_q;
   assign cur_col  = restart ? '0 : col_q;
   assign last_col = (cur_col == CW'(COLS - 1));
   assign last_row = (cur_row == RW'(ROWS - 1));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         row_q <= '0;
         col_q <= '0;
      end else if (step) begin
         if (last_col) begin
            col_q <= '0;
            row_q <= last_row ? '0 : cur_row + 1'b1;
         end else begin
            col_q <= cur_col + 1'b1;
            row_q <= cur_row;
         end
      end
   end

   assert_pos_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (int'(row_q) < ROWS) && (int'(col_q) < COLS));

   assert_frame_wrap_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (step && last_col && last_row) |=> (row_q == '0 && col_q == '0));

   assert_idle_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !step |=> ($stable(row_q) && $stable(col_q)));

endmodule

// File: rtl/stencil_row_mem.sv
module stencil_row_mem #(
   parameter int WIDTH    = 16,
   parameter int DEPTH    = 64,
   parameter int RD_PORTS = 1,
   parameter int AW       = $clog2(DEPTH)
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           wr_en,
   input  logic [AW-1:0]                  wr_addr,
   input  logic [WIDTH-1:0]               wr_data,
   input  logic [RD_PORTS-1:0][AW-1:0]    rd_addr,
   output logic [RD_PORTS-1:0][WIDTH-1:0] rd_data
);

   logic [WIDTH-1:0] mem [DEPTH];

   if (RD_PORTS < 1 || RD_PORTS > 2) begin : g_bad_ports
      $error("stencil_row_mem: RD_PORTS must be 1 or 2");
   end
   if (DEPTH < 2) begin : g_bad_depth
      $error("stencil_row_mem: DEPTH must be at least 2");
   end

   always_ff @(posedge clk) begin
      if (wr_en) mem[wr_addr] <= wr_data;
   end

   for (genvar p = 0; p < RD_PORTS; p++) begin : g_rd
      assign rd_data[p] = mem[rd_addr[p]];

      assert_rd_in_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
         wr_en |-> (int'(rd_addr[p]) < DEPTH));
   end

   assert_wr_in_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> (int'(wr_addr) < DEPTH));

endmodule

// File: rtl/stencil_fifth_scale.sv
module stencil_fifth_scale #(
   parameter int IN_W   = 19,
   parameter int OUT_W  = 16,
   parameter int FRAC_W = 16
) (
   input  logic [IN_W-1:0]  sum,
   output logic [OUT_W-1:0] avg
);

   localparam int unsigned COEF = stencil_pkg::fifth_coef(FRAC_W);
   localparam int          PW   = IN_W + FRAC_W;

   logic [PW-1:0] prod;

   if (FRAC_W < 4 || FRAC_W > 30) begin : g_bad_frac
      $error("stencil_fifth_scale: FRAC_W must lie in 4..30");
   end
   if (IN_W < OUT_W) begin : g_bad_width
      $error("stencil_fifth_scale: IN_W must not be below OUT_W");
   end

   assign prod = (PW'(sum) * PW'(COEF)) + (PW'(1) << (FRAC_W - 1));
   assign avg  = OUT_W'(prod >> FRAC_W);

endmodule

// File: rtl/stencil_reuse_avg.sv
module stencil_reuse_avg #(
   parameter int DATA_W   = 16,
   parameter int ROWS     = 48,
   parameter int COLS     = 64,
   parameter int FRAC_W   = 16,
   parameter int OUT_PIPE = 1,
   parameter int RW       = $clog2(ROWS),
   parameter int CW       = $clog2(COLS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   output logic              in_ready,
   input  logic              in_sof,
   input  logic [DATA_W-1:0] in_data,
   output logic              out_valid,
   output logic [DATA_W-1:0] out_data,
   output logic [RW-1:0]     out_row,
   output logic [CW-1:0]     out_col,
   output logic              out_eol
);

   localparam int TW  = DATA_W + 1;
   localparam int SW  = stencil_pkg::sum5_width(DATA_W);
   localparam int LAT = 1 + OUT_PIPE;

   if (ROWS < 3 || COLS < 3) begin : g_bad_grid
      $error("stencil_reuse_avg: grid needs at least 3 rows and 3 columns");
   end
   if (OUT_PIPE != 0 && OUT_PIPE != 1) begin : g_bad_pipe
      $error("stencil_reuse_avg: OUT_PIPE must be 0 or 1");
   end
   if (DATA_W < 2) begin : g_bad_data
      $error("stencil_reuse_avg: DATA_W must be at least 2");
   end

   // Input side
   logic          ready_q;
   logic          acc;
   logic [RW-1:0] cur_row;
   logic [CW-1:0] cur_col;
   logic [CW-1:0] nb_col;

   always_ff @(posedge clk) begin
      if (!rst_n) ready_q <= 1'b0;
      else        ready_q <= 1'b1;
   end

   assign in_ready = ready_q;
   assign acc      = in_valid & ready_q;

   stencil_raster_pos #(
      .ROWS (ROWS),
      .COLS (COLS),
      .RW   (RW),
      .CW   (CW)
   ) i_pos (
      .clk     (clk),
      .rst_n   (rst_n),
      .step    (acc),
      .restart (in_sof),
      .cur_row (cur_row),
      .cur_col (cur_col)
   );

   assign nb_col = (cur_col == CW'(COLS - 1)) ? '0 : cur_col + 1'b1;

   // Previous-row sample store: port 0 gives the centre, port 1 the up-right sample
   logic [1:0][CW-1:0]     up_addr;
   logic [1:0][DATA_W-1:0] up_data;

   assign up_addr[0] = cur_col;
   assign up_addr[1] = nb_col;

   stencil_row_mem #(
      .WIDTH    (DATA_W),
      .DEPTH    (COLS),
      .RD_PORTS (2),
      .AW       (CW)
   ) i_sample_row (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (acc),
      .wr_addr (cur_col),
      .wr_data (in_data),
      .rd_addr (up_addr),
      .rd_data (up_data)
   );

   // Pair-sum store: one row plus the holding register
   logic [TW-1:0]      pair_new;
   logic [TW-1:0]      pair_hold;
   logic [0:0][CW-1:0] pair_addr;
   logic [0:0][TW-1:0] pair_old;

   assign pair_new     = TW'(up_data[1]) + TW'(in_data);
   assign pair_addr[0] = cur_col;

   always_ff @(posedge clk) begin
      if (!rst_n)   pair_hold <= '0;
      else if (acc) pair_hold <= pair_new;
   end

   stencil_row_mem #(
      .WIDTH    (TW),
      .DEPTH    (COLS),
      .RD_PORTS (1),
      .AW       (CW)
   ) i_pair_row (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (acc),
      .wr_addr (cur_col),
      .wr_data (pair_hold),
      .rd_addr (pair_addr),
      .rd_data (pair_old)
   );

   // Stage 1: three-operand sum of the neighbourhood
   logic          emit;
   logic [SW-1:0] sum5;
   logic          s1_valid;
   logic [SW-1:0] s1_sum;
   logic [RW-1:0] s1_row;
   logic [CW-1:0] s1_col;
   logic          s1_eol;

   assign emit = acc && (int'(cur_row) >= 2) && (int'(cur_col) >= 1)
                 && (int'(cur_col) <= COLS - 2);
   assign sum5 = SW'(pair_old[0]) + SW'(up_data[0]) + SW'(pair_new);

   always_ff @(posedge clk) begin
      if (!rst_n) s1_valid <= 1'b0;
      else        s1_valid <= emit;
   end

   always_ff @(posedge clk) begin
      if (emit) begin
         s1_sum <= sum5;
         s1_row <= cur_row - 1'b1;
         s1_col <= cur_col;
         s1_eol <= (cur_col == CW'(COLS - 2));
      end
   end

   // Scale by one fifth
   logic [DATA_W-1:0] s1_avg;

   stencil_fifth_scale #(
      .IN_W   (SW),
      .OUT_W  (DATA_W),
      .FRAC_W (FRAC_W)
   ) i_scale (
      .sum (s1_sum),
      .avg (s1_avg)
   );

   // Output stage variant
   if (OUT_PIPE == 1) begin : g_out_reg
      always_ff @(posedge clk) begin
         if (!rst_n) out_valid <= 1'b0;
         else        out_valid <= s1_valid;
      end
      always_ff @(posedge clk) begin
         if (s1_valid) begin
            out_data <= s1_avg;
            out_row  <= s1_row;
            out_col  <= s1_col;
            out_eol  <= s1_eol;
         end
      end
   end else begin : g_out_comb
      assign out_valid = s1_valid;
      assign out_data  = s1_avg;
      assign out_row   = s1_row;
      assign out_col   = s1_col;
      assign out_eol   = s1_eol;
   end

   assert_interior_only_R2: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> ((int'(out_row) >= 1) && (int'(out_row) <= ROWS - 2)
                     && (int'(out_col) >= 1) && (int'(out_col) <= COLS - 2)));

   assert_eol_col_R4: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (out_eol == (int'(out_col) == COLS - 2)));

   assert_latency_R5: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> $past(acc, LAT));

   assert_ready_after_reset_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> in_ready);

   assert_no_output_in_reset_R10: assert property (@(posedge clk)
      !rst_n |=> !s1_valid);

endmodule

// File: tb/test_stencil_reuse_avg.sv
module test_stencil_reuse_avg;

   localparam int DW = 16;
   localparam int NR = 5;
   localparam int NC = 6;
   localparam int RW = $clog2(NR);
   localparam int CW = $clog2(NC);

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          in_valid = 1'b0;
   logic          in_sof = 1'b0;
   logic [DW-1:0] in_data = '0;
   logic          in_ready;
   logic          out_valid;
   logic [DW-1:0] out_data;
   logic [RW-1:0] out_row;
   logic [CW-1:0] out_col;
   logic          out_eol;

   always #5 clk = ~clk;

   stencil_reuse_avg #(
      .DATA_W   (DW),
      .ROWS     (NR),
      .COLS     (NC),
      .FRAC_W   (16),
      .OUT_PIPE (1)
   ) i_stencil_reuse_avg (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (in_valid),
      .in_ready  (in_ready),
      .in_sof    (in_sof),
      .in_data   (in_data),
      .out_valid (out_valid),
      .out_data  (out_data),
      .out_row   (out_row),
      .out_col   (out_col),
      .out_eol   (out_eol)
   );

   typedef struct {
      int data;
      int row;
      int col;
      int eol;
      int when;
   } exp_t;

   exp_t q[$];
   int   grid[NR][NC];
   int   br = 0;
   int   bc = 0;
   int   cyc = 0;
   int   checks = 0;
   int   fails = 0;
   bit   done = 1'b0;

   always @(posedge clk) cyc <= cyc + 1;

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // Driver: one sample, after gap idle cycles; pushes the expected result
   task automatic send(input int d, input bit sof, input int gap);
      for (int g = 0; g < gap; g++) begin
         @(negedge clk);
         in_valid = 1'b0;
         in_sof   = 1'b0;
      end
      @(negedge clk);
      in_valid = 1'b1;
      in_sof   = sof;
      in_data  = DW'(d);
      if (sof) begin
         br = 0;
         bc = 0;
      end
      grid[br][bc] = d;
      if (br >= 2 && bc >= 1 && bc <= NC - 2) begin
         longint s;
         exp_t   e;
         s = longint'(grid[br-2][bc]) + grid[br-1][bc-1] + grid[br-1][bc]
             + grid[br-1][bc+1] + grid[br][bc];
         e.data = int'((s * 13107 + 32768) >>> 16);
         e.row  = br - 1;
         e.col  = bc;
         e.eol  = (bc == NC - 2) ? 1 : 0;
         e.when = cyc + 2;
         q.push_back(e);
      end
      if (bc == NC - 1) begin
         bc = 0;
         br = (br == NR - 1) ? 0 : br + 1;
      end else begin
         bc++;
      end
   endtask

   task automatic quiet(input int n);
      for (int k = 0; k < n; k++) begin
         @(negedge clk);
         in_valid = 1'b0;
         in_sof   = 1'b0;
      end
   endtask

   // kind: 0 ramp, 1 random, 2 all maximum, 3 all zero
   task automatic frame(input int kind, input bit sof, input bit gaps);
      for (int r = 0; r < NR; r++) begin
         for (int c = 0; c < NC; c++) begin
            int d;
            case (kind)
               0:       d = (r * 977 + c * 131 + 7) % 65536;
               1:       d = int'($urandom_range(0, 65535));
               2:       d = 65535;
               default: d = 0;
            endcase
            send(d, sof && r == 0 && c == 0, gaps ? int'($urandom_range(0, 3)) : 0);
         end
      end
   endtask

   // Monitor: scoreboard comparison
   always @(negedge clk) begin
      if (rst_n && out_valid) begin
         if (q.size() == 0) begin
            chk(1'b0, "R2 result with no expected item", 1, 0);
         end else begin
            exp_t e;
            e = q.pop_front();
            chk(int'(out_data) == e.data, "R1 average value", int'(out_data), e.data);
            chk(int'(out_row) == e.row, "R3 row tag", int'(out_row), e.row);
            chk(int'(out_col) == e.col, "R3 column tag", int'(out_col), e.col);
            chk(int'(out_eol) == e.eol, "R4 end-of-row flag", int'(out_eol), e.eol);
            chk(cyc == e.when, "R5 result cycle", cyc, e.when);
         end
      end
   end

   initial begin
      for (int k = 0; k < 3; k++) begin
         @(negedge clk);
         chk(in_ready == 1'b0, "R8 ready low in reset", int'(in_ready), 0);
         chk(out_valid == 1'b0, "R10 no result in reset", int'(out_valid), 0);
      end
      rst_n = 1'b1;
      @(negedge clk);
      chk(in_ready == 1'b1, "R8 ready high after reset", int'(in_ready), 1);
      chk(out_valid == 1'b0, "R10 idle after reset", int'(out_valid), 0);

      frame(0, 1'b1, 1'b0);   // R1 ramp
      frame(1, 1'b1, 1'b1);   // R7 random with gaps
      frame(2, 1'b1, 1'b0);   // R1 maximum rounding
      frame(3, 1'b1, 1'b1);   // R1 zero frame

      // R6: abandon a frame after two rows and three samples, then restart
      for (int k = 0; k < 2 * NC + 3; k++) begin
         send(int'($urandom_range(0, 65535)), k == 0, 0);
      end
      frame(1, 1'b1, 1'b0);

      // R9: frames following each other with no frame-start flag
      frame(1, 1'b1, 1'b0);
      frame(1, 1'b0, 1'b0);
      frame(0, 1'b0, 1'b1);

      quiet(8);
      chk(q.size() == 0, "R2 every interior result produced", q.size(), 0);
      chk(out_valid == 1'b0, "R7 no result while idle", int'(out_valid), 0);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      #1000000;
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

endmodule